// File: doc/BRIEF.md
# Gated Peripheral Clock-Enable Divider

This block produces a one-cycle clock-enable pulse for a peripheral. It divides one of two source rates by an integer. Both sources arrive as single-cycle tick enables in the block's own clock domain. The first is a crystal-rate reference tick and the second is a fractional I/O tick. A source-select input chooses between them.

Software controls the block through one 32-bit control word. The word holds three fields:
- a stop bit, which silences the output and holds the counter;
- a read-only busy flag;
- a 9-bit divide ratio.

A new ratio is not applied at once. It is kept as a pending value and moved into the live counter only when the current count period ends. The busy flag stays high until that happens. While the output is stopped, the ratio field of any write is discarded. Clearing the stop bit restarts counting from zero.

Top module: `pdiv_gated_divider`

## Requirements
- R1: After reset the control word reads 0x8000_0001 (stopped, ratio 1, not busy) and `div_en` is low.
- R2: The control word read on `rd_data` has the stop bit at bit 31, the busy flag at bit 29 and the ratio at bits [8:0]. All other bits read 0.
- R3: While the stop bit is set, `div_en` stays low and the counter is held at zero.
- R4: A write made while the stop bit is set leaves the ratio field and the busy flag unchanged.
- R5: With `src_sel` high, only `xtal_tick` advances the counter. With `src_sel` low, only `io_tick` advances it.
- R6: While running with live ratio N, `div_en` pulses once for every N selected ticks. The pulse is high for one cycle, in the cycle after the Nth tick was sampled.
- R7: A ratio of 0 behaves as a ratio of 1, so every selected tick produces a pulse.
- R8: A write made while running stores the new ratio and raises busy from the next cycle. At the next period end, the ratio becomes live and busy reads 0 from the following cycle on.
- R9: After a write clears the stop bit, the first pulse follows exactly N selected ticks, counted from the first tick after that write.
- R10: Every write updates the stop bit from `wr_data[31]`, whether or not the ratio field is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word readback |
| src_sel | input | 1 | 1 selects the crystal tick, 0 selects the I/O tick |
| xtal_tick | input | 1 | Crystal-rate source enable |
| io_tick | input | 1 | Fractional I/O source enable |
| div_en | output | 1 | Divided clock-enable pulse |

## Verification
A write sampled at one clock edge shows on `rd_data` just after that edge. The busy flag is already set then. Busy drops just after the edge at which the period-ending tick is sampled. The `div_en` pulse appears in the cycle after the edge that sampled the Nth tick.

The bench drives all inputs on the falling edge and compares every output on the falling edge. It checks each cycle against a reference state advanced on the rising edge, so every comparison lands one register stage after its cause. Directed segments also count pulses over fixed windows, and check the exact cycle of the first pulse after the stop bit is cleared.

// File: rtl/pdiv_pkg.sv
// Package: shared field positions of the divider control word.
// Assumes a 32-bit control word; field positions are decoded by software.
package pdiv_pkg;
    localparam int CTRL_W   = 32;
    localparam int STOP_BIT = 31;
    localparam int BUSY_BIT = 29;
    localparam int RATIO_LO = 0;
endpackage

// File: rtl/pdiv_src_mux.sv
// Module: chooses which source tick advances the divider.
// Assumes both ticks are single-cycle enables in the block clock domain.
module pdiv_src_mux (
    input  logic src_sel,
    input  logic xtal_tick,
    input  logic io_tick,
    output logic tick
);
    // Select crystal tick when src_sel is high, I/O tick otherwise.
    always_comb begin
        tick = src_sel ? xtal_tick : io_tick;
    end
endmodule

// File: rtl/pdiv_ctrl.sv
// Module: control word storage, pending/live ratio and busy handshake.
// Assumes period_end is a one-cycle strobe from the counter marking a safe boundary.
module pdiv_ctrl
    import pdiv_pkg::*;
#(
    parameter int RATIO_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CTRL_W-1:0]  wr_data,
    input  logic               period_end,
    output logic               stop_q,
    output logic [RATIO_W-1:0] live_q,
    output logic [CTRL_W-1:0]  rd_data
);
    logic [RATIO_W-1:0] pend_q;
    logic               busy_q;
    logic               accept_ratio;
    logic               apply_ratio;

    assign accept_ratio = wr_en && !stop_q;
    assign apply_ratio  = period_end && busy_q;

    // Stop bit: written by every write.
    always_ff @(posedge clk) begin
        if (!rst_n)     stop_q <= 1'b1;
        else if (wr_en) stop_q <= wr_data[STOP_BIT];
    end

    // Pending ratio: accepted only while running.
    always_ff @(posedge clk) begin
        if (!rst_n)            pend_q <= RATIO_W'(1);
        else if (accept_ratio) pend_q <= wr_data[RATIO_LO +: RATIO_W];
    end

    // Busy: set by an accepted write, cleared when the ratio goes live.
    always_ff @(posedge clk) begin
        if (!rst_n)            busy_q <= 1'b0;
        else if (accept_ratio) busy_q <= 1'b1;
        else if (apply_ratio)  busy_q <= 1'b0;
    end

    // Live ratio: copied from pending at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)           live_q <= RATIO_W'(1);
        else if (apply_ratio) live_q <= pend_q;
    end

    // Readback assembly of the control word.
    always_comb begin
        rd_data = '0;
        rd_data[STOP_BIT] = stop_q;
        rd_data[BUSY_BIT] = busy_q;
        rd_data[RATIO_LO +: RATIO_W] = pend_q;
    end

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[CTRL_W-2:RATIO_W]};

    // R4
    stopped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && stop_q) |=> ($stable(pend_q) && $stable(busy_q)));

    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(wr_en && !stop_q));

    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(period_end));

    // R8
    live_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(live_q) |-> $past(period_end && busy_q));
endmodule

// File: rtl/pdiv_count.sv
// Module: counts selected ticks and emits a registered pulse each period.
// Assumes live_ratio changes only at a period end; ratio 0 is treated as 1.
module pdiv_count #(
    parameter int RATIO_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               stop,
    input  logic [RATIO_W-1:0] live_ratio,
    output logic               period_end,
    output logic               pulse_q
);
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] eff_ratio;

    // Effective ratio: zero maps to one.
    always_comb begin
        eff_ratio = (live_ratio == '0) ? RATIO_W'(1) : live_ratio;
    end

    // Period end: last tick of the period while running.
    always_comb begin
        period_end = !stop && tick && (cnt_q == eff_ratio - RATIO_W'(1));
    end

    // Counter: held at zero while stopped, wraps at period end.
    always_ff @(posedge clk) begin
        if (!rst_n || stop)  cnt_q <= '0;
        else if (period_end) cnt_q <= '0;
        else if (tick)       cnt_q <= cnt_q + RATIO_W'(1);
    end

    // Output pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= period_end;
    end

    // R3
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> !$past(stop));

    // R3
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (cnt_q == '0));

    // R6
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < eff_ratio);

    // R6
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> $past(tick));
endmodule

// File: rtl/pdiv_gated_divider.sv
// Module: top of the gated peripheral clock-enable divider.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module pdiv_gated_divider
    import pdiv_pkg::*;
#(
    parameter int RATIO_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              src_sel,
    input  logic              xtal_tick,
    input  logic              io_tick,
    output logic              div_en
);
    logic               tick;
    logic               stop;
    logic               period_end;
    logic [RATIO_W-1:0] live_ratio;

    pdiv_src_mux u_mux (
        .src_sel   (src_sel),
        .xtal_tick (xtal_tick),
        .io_tick   (io_tick),
        .tick      (tick)
    );

    pdiv_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .period_end (period_end),
        .stop_q     (stop),
        .live_q     (live_ratio),
        .rd_data    (rd_data)
    );

    pdiv_count #(.RATIO_W(RATIO_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .stop       (stop),
        .live_ratio (live_ratio),
        .period_end (period_end),
        .pulse_q    (div_en)
    );

    // R5
    source_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_en |-> $past(src_sel ? xtal_tick : io_tick));
endmodule

// File: tb/pdiv_gated_divider_bench.sv
module pdiv_gated_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        src_sel = 1'b1;
    logic        xtal_tick = 1'b0;
    logic        io_tick = 1'b0;
    logic        div_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    pdiv_gated_divider u_pdiv_gated_divider (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .src_sel(src_sel), .xtal_tick(xtal_tick),
        .io_tick(io_tick), .div_en(div_en)
    );

    // Reference state built from the requirements.
    logic       m_stop, m_busy, m_out;
    logic [8:0] m_pend, m_live, m_cnt;

    function automatic logic [8:0] eff(input logic [8:0] r);
        return (r == 0) ? 9'd1 : r;
    endfunction

    function automatic logic [31:0] word(input logic s, input logic b, input logic [8:0] r);
        return {s, 1'b0, b, 20'd0, r};
    endfunction

    always @(posedge clk) begin
        logic t, term;
        if (!rst_n) begin
            m_stop <= 1'b1; m_busy <= 1'b0; m_out <= 1'b0;
            m_pend <= 9'd1; m_live <= 9'd1; m_cnt <= '0;
        end else begin
            t    = src_sel ? xtal_tick : io_tick;
            term = !m_stop && t && (m_cnt == eff(m_live) - 9'd1);
            m_out <= term;
            if (m_stop || term) m_cnt <= '0;
            else if (t)         m_cnt <= m_cnt + 9'd1;
            if (term && m_busy) begin m_live <= m_pend; m_busy <= 1'b0; end
            if (wr_en) begin
                m_stop <= wr_data[31];
                if (!m_stop) begin m_pend <= wr_data[8:0]; m_busy <= 1'b1; end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference (R2, R6, R8).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2/R8 rd_data", rd_data, word(m_stop, m_busy, m_pend));
            chk("R6 div_en", {31'd0, div_en}, {31'd0, m_out});
        end
    end

    task automatic wr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic count_pulses(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (div_en) n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset word", rd_data, 32'h8000_0001);
        chk("R1 reset div_en", {31'd0, div_en}, 32'd0);

        // R4 R10: ratio ignored while stopped, stop bit still cleared
        xtal_tick = 1'b0;
        wr(32'h0000_0005);
        chk("R4 R10 stopped write", rd_data, 32'h0000_0001);

        // R7: ratio 0 acts as 1
        wr(32'h0000_0000);
        xtal_tick = 1'b1; src_sel = 1'b1;
        @(negedge clk); @(negedge clk);
        count_pulses(8, n);
        chk("R7 ratio zero pulses", n, 8);

        // R8: busy visible then cleared after period end
        @(negedge clk); wr_en = 1'b1; wr_data = 32'h0000_0004;
        @(negedge clk); wr_en = 1'b0;
        chk("R8 busy set", rd_data, 32'h2000_0004);
        @(negedge clk);
        chk("R8 busy cleared", rd_data, 32'h0000_0004);
        repeat (4) @(negedge clk);
        count_pulses(40, n);
        chk("R6 ratio 4 pulse count", n, 10);

        // R5: deselected source does not advance
        src_sel = 1'b0; io_tick = 1'b0;
        count_pulses(20, n);
        chk("R5 io source idle", n, 0);
        io_tick = 1'b1;
        count_pulses(40, n);
        chk("R5 io source active", n, 10);
        src_sel = 1'b1;

        // R3: stopped output quiet
        wr(32'h8000_0004);
        @(negedge clk);
        count_pulses(20, n);
        chk("R3 stopped pulses", n, 0);

        // R9: restart from zero, first pulse after exactly 4 ticks
        wr(32'h0000_0004);
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            chk("R9 restart timing", {31'd0, div_en}, (i == 4) ? 32'd1 : 32'd0);
        end

        // Constrained random phase with fixed seed
        void'($urandom(32'h1234));
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            xtal_tick = ($urandom_range(0, 2) != 0);
            io_tick   = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 49) == 0) src_sel = ~src_sel;
            wr_en = ($urandom_range(0, 24) == 0);
            wr_data = $urandom;
            wr_data[31] = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 7) != 0) wr_data[8:0] = 9'($urandom_range(0, 7));
        end
        @(negedge clk); wr_en = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule